// File: doc/BRIEF.md
# Video Timing Reference Detector with Extreme-Value Clipping

This block sits on a 10-bit parallel video word stream, one word per clock, just ahead of the scrambling encoder. Every incoming word first passes through a clipper. Codes in the lowest group (000h to 003h) are forced to 000h. Codes in the highest group (3FCh to 3FFh) are forced to 3FFh. The clipped word is registered and handed downstream with one cycle of latency.

A four-state machine watches the clipped stream for the timing reference preamble: 3FFh, then 000h, then 000h. The word that follows the preamble is the identifier word. When that identifier word leaves the block, the block raises a reference flag on the same cycle. The identifier's bit 6 marks the word as end of active video (bit set) or start of active video (bit clear). An active-video indication is derived from these events so that the encoder knows when picture data is flowing.

Detection is enabled by an active-low input. While that input is high, words still pass through clipped, but the machine is held in its hunting state and every flag is held low.

The states are HUNT (no preamble progress), ONES (3FFh seen), ZERO1 (3FFh, 000h seen) and ZERO2 (full preamble seen). The transitions are:
- Any state goes to ONES on a 3FFh word.
- ONES goes to ZERO1 on 000h.
- ZERO1 goes to ZERO2 on 000h.
- ZERO2 goes back to HUNT on the identifier word, or to ONES if that word is 3FFh.
- Any other word returns the machine to HUNT.
- Disabling detection or reset forces the machine to HUNT.

Top module: `vid_sync_detect`

## Requirements
- R1: An active-low reset (asynchronous) drives word_o to 000h, clears trs_o, sav_o, eav_o and active_o, and discards any preamble progress, so a word following a preamble that was interrupted by reset raises no flag.
- R2: An input word of 000h to 003h appears on word_o as 000h one clock later.
- R3: An input word of 3FCh to 3FFh appears on word_o as 3FFh one clock later.
- R4: An input word of 004h to 3FBh appears unchanged on word_o one clock later.
- R5: When the clipped words 3FFh, 000h, 000h arrive on consecutive clocks with detection enabled, trs_o is high for exactly the cycle in which the next (identifier) word is on word_o, and it is low otherwise.
- R6: With trs_o high, eav_o equals bit 6 of word_o and sav_o is its inverse. Neither sav_o nor eav_o is ever high without trs_o.
- R7: Any word that breaks the preamble returns the search to its start. A 3FFh word always counts as a fresh first preamble word.
- R8: While det_en_n is high, trs_o, sav_o, eav_o and active_o are low one clock later, and clipping still applies. Preamble words received while detection was disabled do not count.
- R9: active_o rises together with sav_o and falls together with eav_o, and it holds its value between those events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_en_n | input | 1 | Detection enable, active low |
| word_i | input | 10 | Incoming parallel video word |
| word_o | output | 10 | Clipped word, one cycle later |
| trs_o | output | 1 | Identifier word of a reference sequence is on word_o |
| sav_o | output | 1 | That identifier marks start of active video |
| eav_o | output | 1 | That identifier marks end of active video |
| active_o | output | 1 | Active picture data is flowing |

## Verification
Assertions check on every cycle that the clipping bands map to the rail codes one clock later. They also check that every trs_o pulse is preceded on word_o by 3FFh, 000h, 000h, that sav_o and eav_o never appear without trs_o or together, that a disabled detector raises no flag, and that active_o changes only on a start or end event. Only the bench scenarios show the following: that a valid preamble really produces a flag, that broken or restarted preambles and disabled spans are handled as specified, and that a reset in the middle of a preamble discards its progress.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    // Preamble search states
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ONES  = 2'd1,
        ST_ZERO1 = 2'd2,
        ST_ZERO2 = 2'd3
    } trs_state_e;

endpackage

// File: rtl/vsd_clip.sv
module vsd_clip #(
    parameter int W         = 10,
    parameter int CLIP_BITS = 2
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int UW = W - CLIP_BITS;

    logic [UW-1:0] upper;
    assign upper = din[W-1:CLIP_BITS];

    always_comb begin
        if (upper == '0) begin
            dout = '0;
        end else if (upper == '1) begin
            dout = '1;
        end else begin
            dout = din;
        end
    end
endmodule

// File: rtl/vsd_fsm.sv
module vsd_fsm
    import vsd_pkg::*;
#(
    parameter int W        = 10,
    parameter int FLAG_BIT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         det_en,
    input  logic [W-1:0] cword,
    output logic         hit,
    output logic         hit_eav
);
    localparam logic [W-1:0] ONES_CODE = '1;
    localparam logic [W-1:0] ZERO_CODE = '0;

    trs_state_e state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = ST_HUNT;
        if (!det_en) begin
            state_nx = ST_HUNT;
        end else if (cword == ONES_CODE) begin
            state_nx = ST_ONES;
        end else begin
            unique case (state)
                ST_HUNT:  state_nx = ST_HUNT;
                ST_ONES:  state_nx = (cword == ZERO_CODE) ? ST_ZERO1 : ST_HUNT;
                ST_ZERO1: state_nx = (cword == ZERO_CODE) ? ST_ZERO2 : ST_HUNT;
                ST_ZERO2: state_nx = ST_HUNT;
                default:  state_nx = ST_HUNT;
            endcase
        end
    end

    // Outputs of the machine
    always_comb begin
        hit     = det_en && (state == ST_ZERO2);
        hit_eav = cword[FLAG_BIT];
    end

    AST_DISABLED_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> (state == ST_HUNT)); // R8
endmodule

// File: rtl/vsd_outreg.sv
module vsd_outreg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         det_en,
    input  logic [W-1:0] cword,
    input  logic         hit,
    input  logic         hit_eav,
    output logic [W-1:0] word_q,
    output logic         trs_q,
    output logic         sav_q,
    output logic         eav_q,
    output logic         act_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            trs_q  <= 1'b0;
            sav_q  <= 1'b0;
            eav_q  <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            word_q <= cword;
            trs_q  <= hit;
            sav_q  <= hit && !hit_eav;
            eav_q  <= hit && hit_eav;
            if (!det_en) begin
                act_q <= 1'b0;
            end else if (hit) begin
                act_q <= !hit_eav;
            end
        end
    end

    AST_ACT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> sav_q); // R9
    AST_ACT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_q) |-> (eav_q || $past(!det_en))); // R9
endmodule

// File: rtl/vid_sync_detect.sv
module vid_sync_detect #(
    parameter int W         = 10,
    parameter int CLIP_BITS = 2,
    parameter int FLAG_BIT  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         det_en_n,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o,
    output logic         trs_o,
    output logic         sav_o,
    output logic         eav_o,
    output logic         active_o
);
    localparam logic [W-1:0] LOW_TOP  = W'((1 << CLIP_BITS) - 1);
    localparam logic [W-1:0] HIGH_BOT = ~LOW_TOP;

    logic [W-1:0] cword;
    logic         det_en;
    logic         hit;
    logic         hit_eav;

    assign det_en = !det_en_n;

    vsd_clip #(.W(W), .CLIP_BITS(CLIP_BITS)) u_clip (
        .din  (word_i),
        .dout (cword)
    );

    vsd_fsm #(.W(W), .FLAG_BIT(FLAG_BIT)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .det_en  (det_en),
        .cword   (cword),
        .hit     (hit),
        .hit_eav (hit_eav)
    );

    vsd_outreg #(.W(W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .det_en  (det_en),
        .cword   (cword),
        .hit     (hit),
        .hit_eav (hit_eav),
        .word_q  (word_o),
        .trs_q   (trs_o),
        .sav_q   (sav_o),
        .eav_q   (eav_o),
        .act_q   (active_o)
    );

    AST_CLIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (word_i <= LOW_TOP) |=> (word_o == '0)); // R2
    AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (word_i >= HIGH_BOT) |=> (word_o == '1)); // R3
    AST_PASS_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (word_i > LOW_TOP && word_i < HIGH_BOT) |=> (word_o == $past(word_i))); // R4
    AST_TRS_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        trs_o |-> ($past(word_o, 1) == '0 && $past(word_o, 2) == '0
                   && $past(word_o, 3) == '1)); // R5
    AST_KIND_NEEDS_TRS: assert property (@(posedge clk) disable iff (!rst_n)
        (sav_o || eav_o) |-> (trs_o && !(sav_o && eav_o))); // R6
    AST_EAV_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        trs_o |-> (eav_o == word_o[FLAG_BIT])); // R6
    AST_FLAGS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        det_en_n |=> !(trs_o || sav_o || eav_o || active_o)); // R8
endmodule

// File: tb/vid_sync_detect_test.sv
module vid_sync_detect_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_en_n = 1'b0;
    logic [9:0] word_i = '0;
    logic [9:0] word_o;
    logic       trs_o, sav_o, eav_o, active_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vid_sync_detect uut (
        .clk(clk), .rst_n(rst_n), .det_en_n(det_en_n), .word_i(word_i),
        .word_o(word_o), .trs_o(trs_o), .sav_o(sav_o), .eav_o(eav_o),
        .active_o(active_o)
    );

    typedef struct packed {
        logic       en_n;
        logic [9:0] din;
        logic [9:0] ew;
        logic       et, es, ee, ea;
        logic [3:0] wreq;
        logic [3:0] freq;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'h200, 10'h200, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd5},
        '{1'b0, 10'h3FF, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd5},
        '{1'b0, 10'h001, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd5},
        '{1'b0, 10'h003, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd5},
        '{1'b0, 10'h200, 10'h200, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4, 4'd6},
        '{1'b0, 10'h123, 10'h123, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 4'd9},
        '{1'b0, 10'h3FD, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 4'd9},
        '{1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 4'd9},
        '{1'b0, 10'h002, 10'h000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 4'd9},
        '{1'b0, 10'h274, 10'h274, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4, 4'd6},
        '{1'b0, 10'h004, 10'h004, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd5},
        '{1'b0, 10'h3FB, 10'h3FB, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd5},
        '{1'b0, 10'h3FF, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd7},
        '{1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd7},
        '{1'b0, 10'h155, 10'h155, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd7},
        '{1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd7},
        '{1'b0, 10'h280, 10'h280, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd7},
        '{1'b0, 10'h3FF, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd7},
        '{1'b0, 10'h3FF, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd7},
        '{1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd7},
        '{1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd7},
        '{1'b0, 10'h2AC, 10'h2AC, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4, 4'd7},
        '{1'b1, 10'h3FF, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd8},
        '{1'b1, 10'h001, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd8},
        '{1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd8},
        '{1'b0, 10'h2C4, 10'h2C4, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd8},
        '{1'b0, 10'h3FF, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd8},
        '{1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd8},
        '{1'b0, 10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd8},
        '{1'b1, 10'h200, 10'h200, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd8}
    };

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic en_n, input logic [9:0] d);
        det_en_n = en_n;
        word_i   = d;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        chk("R1", "word", word_o, 10'h000);
        chk("R1", "flags", {6'd0, trs_o, sav_o, eav_o, active_o}, 10'h000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].en_n, VECS[i].din);
            chk(tag(VECS[i].wreq), "word", word_o, VECS[i].ew);
            chk(tag(VECS[i].freq), "trs/sav/eav",
                {7'd0, trs_o, sav_o, eav_o}, {7'd0, VECS[i].et, VECS[i].es, VECS[i].ee});
            chk("R9", "active", {9'd0, active_o}, {9'd0, VECS[i].ea});
        end

        // R1: reset during a preamble discards progress
        step(1'b0, 10'h3FF);
        step(1'b0, 10'h000);
        step(1'b0, 10'h000);
        step(1'b0, 10'h200);
        chk("R5", "trs before reset test", {9'd0, trs_o}, 10'd1);
        chk("R9", "active before reset", {9'd0, active_o}, 10'd1);
        step(1'b0, 10'h3FF);
        step(1'b0, 10'h000);
        step(1'b0, 10'h000);
        #3 rst_n = 1'b0;
        #2;
        chk("R1", "word in reset", word_o, 10'h000);
        chk("R1", "flags in reset", {6'd0, trs_o, sav_o, eav_o, active_o}, 10'h000);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 10'h200);
        chk("R1", "no trs after reset", {9'd0, trs_o}, 10'd0);
        chk("R4", "word after reset", word_o, 10'h200);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule